// File: doc/BRIEF.md
# Power-Down Alarm Wake Controller

This block moves a processor system into a state where its internal global clock is stopped, and brings it back out again. It runs on an always-on clock, so it keeps working while everything it gates is halted. Software first writes a countdown value into the alarm register. It then writes a start command to the control register. If no interrupt is pending at that moment, the controller asks the system to reach an idle point. Once the system acknowledges, it drops the global clock enable. It can also ask for the PLL to be switched off, depending on a configuration bit.

While the clock is stopped, the timer counts down by one on each slow tick. The system wakes when the interrupt pin goes high or when the timer reaches zero. A status register records which source caused the wake. If the PLL was stopped, the clock enable is returned only after the PLL reports lock. Otherwise it comes back one cycle after the wake. All register contents are kept across the stop, so software can read the remaining count after an early wake. A start command given while an interrupt is outstanding is refused and flagged in the status register. A start with an alarm value of zero wakes at once, without ever stopping the clock.

Register map (2-bit address):
- Address 0 is the alarm reload value (read/write).
- Address 1 is the control register. Writing bit 0 as 1 issues a start, and bit 1 selects whether the PLL is stopped. Reading it returns bit 1.
- Address 2 is the timer (read/write).
- Address 3 is the read-only status register. Bit 0 means a pin wake, bit 1 an alarm wake and bit 2 a refused start.

Top module: `pdwake_ctrl`

## Requirements
- R1: After reset, clkEnable is 1, pllOff is 0 and pdActive is 0, and the alarm, timer, control and status registers all read 0.
- R2: The alarm (address 0) and timer (address 2) registers return on regRdData the last value written while the controller is running.
- R3: A start (write to address 1 with bit 0 set) while irqPending or irqPin is high is refused. Status reads 3'b100, and clkEnable stays 1 and pdActive stays 0.
- R4: An accepted start loads the timer from the alarm register, clears the status register and raises pdActive. clkEnable stays 1 while idleAck is low. It goes to 0 in the cycle after idleAck is sampled high.
- R5: While the clock is stopped, the timer decreases by exactly one for each cycle in which slowTick is high.
- R6: irqPin high while the clock is stopped causes a wake and sets status bit 0 (status 3'b001).
- R7: The timer reaching zero causes a wake and sets status bit 1 (3'b010). If the pin and expiry occur in the same cycle, status reads 3'b011.
- R8: pllOff is 1 only while the clock is stopped with control bit 1 set. It falls to 0 as soon as the wake begins, and it stays 0 throughout when bit 1 is clear.
- R9: With control bit 1 set, clkEnable returns in the cycle after pllLock is sampled high during the wake. With bit 1 clear, it returns one cycle after the wake.
- R10: A start with the alarm register at 0 sets status to 3'b010 immediately. It never drops clkEnable and never raises pdActive.
- R11: After a pin wake, the timer keeps the count reached at the moment of the wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | CNT_W | Register write data |
| regRdData | output | CNT_W | Register read data (combinational) |
| irqPending | input | 1 | An interrupt is pending in the system |
| irqPin | input | 1 | External interrupt pin (wake source) |
| slowTick | input | 1 | One-cycle countdown tick from the slow time base |
| idleAck | input | 1 | System confirms it reached an idle point |
| pllLock | input | 1 | PLL reports stable clock |
| clkEnable | output | 1 | Enable for the internal global clock |
| pllOff | output | 1 | Request to stop the PLL |
| pdActive | output | 1 | A power-down sequence is in progress |

## Verification
A control state that is off by one would show up straight away as a clkEnable edge one cycle too early or too late around idleAck, the wake and pllLock. The bench samples every one of those cycles. A decrement that is wrong or missing during the stop shows up as a wrong remaining count at address 2 after a pin wake. It also shows up as an alarm wake on the wrong tick, which the bench catches in the cycle right after the expected tick. A wrong cause or refusal flag appears in the status register in the cycle after the event.

// File: rtl/pdwake_pkg.sv
package pdwake_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_ENTER = 2'd1,
    ST_DOWN  = 2'd2,
    ST_WAKE  = 2'd3
  } pdState_e;

  typedef struct packed {
    logic loadTimer;
    logic decTimer;
    logic clearStatus;
    logic setReject;
    logic causePin;
    logic causeAlarm;
  } pdStrobe_t;

  localparam logic [1:0] ADDR_ALARM  = 2'd0;
  localparam logic [1:0] ADDR_CTRL   = 2'd1;
  localparam logic [1:0] ADDR_TIMER  = 2'd2;
  localparam logic [1:0] ADDR_STATUS = 2'd3;
endpackage

// File: rtl/pdwake_fsm.sv
module pdwake_fsm
  import pdwake_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      pllStopCfg,
  input  logic      alarmIsZero,
  input  logic      timerIsOne,
  input  logic      irqPending,
  input  logic      irqPin,
  input  logic      slowTick,
  input  logic      idleAck,
  input  logic      pllLock,
  output pdStrobe_t strobe,
  output logic      clkEnable,
  output logic      pllOff,
  output logic      pdActive
);
  pdState_e stateQ, stateD;
  logic blocked, expire;

  assign blocked = irqPending | irqPin;
  assign expire  = slowTick & timerIsOne;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_RUN: begin
        if (startReq) begin
          strobe.clearStatus = 1'b1;
          if (blocked) begin
            strobe.setReject = 1'b1;
          end else if (alarmIsZero) begin
            strobe.causeAlarm = 1'b1;
          end else begin
            strobe.loadTimer = 1'b1;
            stateD = ST_ENTER;
          end
        end
      end
      ST_ENTER: if (idleAck) stateD = ST_DOWN;
      ST_DOWN: begin
        strobe.decTimer   = slowTick;
        strobe.causePin   = irqPin;
        strobe.causeAlarm = expire;
        if (irqPin || expire) stateD = ST_WAKE;
      end
      ST_WAKE: if (!pllStopCfg || pllLock) stateD = ST_RUN;
      default: stateD = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_RUN;
    else       stateQ <= stateD;
  end

  assign clkEnable = (stateQ == ST_RUN) || (stateQ == ST_ENTER);
  assign pllOff    = (stateQ == ST_DOWN) && pllStopCfg;
  assign pdActive  = (stateQ != ST_RUN);

  // R4: clock stays enabled while the idle handshake is outstanding
  a_r4_hold_until_ack: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ENTER && !idleAck) |=> clkEnable);
  // R3: a refused start leaves the controller running
  a_r3_refuse_stays: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RUN && startReq && blocked) |=> (clkEnable && !pdActive));
  // R8: PLL stop request only when configured
  a_r8_pll_cfg: assert property (@(posedge clk) disable iff (!rstN)
    pllOff |-> (pllStopCfg && !clkEnable));
  // R9: no clock release before lock when the PLL was stopped
  a_r9_wait_lock: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAKE && pllStopCfg && !pllLock) |=> !clkEnable);
endmodule

// File: rtl/pdwake_regs.sv
module pdwake_regs
  import pdwake_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [CNT_W-1:0] regWrData,
  output logic [CNT_W-1:0] regRdData,
  input  pdStrobe_t        strobe,
  output logic             startReq,
  output logic             pllStopCfg,
  output logic             alarmIsZero,
  output logic             timerIsOne
);
  localparam int STAT_W = 3;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0]  alarmQ, timerQ;
  logic [STAT_W-1:0] statusQ, statusD;
  logic              pllStopQ;
  logic              wrAlarm, wrCtrl, wrTimer;

  assign wrAlarm = regWrEn && (regAddr == ADDR_ALARM);
  assign wrCtrl  = regWrEn && (regAddr == ADDR_CTRL);
  assign wrTimer = regWrEn && (regAddr == ADDR_TIMER);

  assign startReq    = wrCtrl && regWrData[0];
  assign pllStopCfg  = pllStopQ;
  assign alarmIsZero = (alarmQ == '0);
  assign timerIsOne  = (timerQ == ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alarmQ   <= '0;
      pllStopQ <= 1'b0;
    end else begin
      if (wrAlarm) alarmQ <= regWrData;
      if (wrCtrl)  pllStopQ <= regWrData[1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 timerQ <= '0;
    else if (strobe.loadTimer) timerQ <= alarmQ;
    else if (strobe.decTimer && timerQ != '0) timerQ <= timerQ - ONE;
    else if (wrTimer)          timerQ <= regWrData;
  end

  always_comb begin
    statusD = strobe.clearStatus ? '0 : statusQ;
    if (strobe.causePin)   statusD[0] = 1'b1;
    if (strobe.causeAlarm) statusD[1] = 1'b1;
    if (strobe.setReject)  statusD[2] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= statusD;
  end

  always_comb begin
    unique case (regAddr)
      ADDR_ALARM: regRdData = alarmQ;
      ADDR_CTRL:  regRdData = CNT_W'({pllStopQ, 1'b0});
      ADDR_TIMER: regRdData = timerQ;
      default:    regRdData = CNT_W'(statusQ);
    endcase
  end

  // R5: one step down per tick while stopped
  a_r5_dec_one: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.decTimer && timerQ != '0) |=> (timerQ == $past(timerQ) - ONE));
  // R7: simultaneous causes both recorded
  a_r7_both_causes: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.causePin && strobe.causeAlarm) |=> (statusQ[1:0] == 2'b11));
  // R4: an accepted start copies the alarm value
  a_r4_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadTimer |=> (timerQ == $past(alarmQ)));
endmodule

// File: rtl/pdwake_ctrl.sv
module pdwake_ctrl
  import pdwake_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [CNT_W-1:0] regWrData,
  output logic [CNT_W-1:0] regRdData,
  input  logic             irqPending,
  input  logic             irqPin,
  input  logic             slowTick,
  input  logic             idleAck,
  input  logic             pllLock,
  output logic             clkEnable,
  output logic             pllOff,
  output logic             pdActive
);
  pdStrobe_t strobe;
  logic startReq, pllStopCfg, alarmIsZero, timerIsOne;

  pdwake_fsm uFsm (
    .clk(clk), .rstN(rstN), .startReq(startReq), .pllStopCfg(pllStopCfg),
    .alarmIsZero(alarmIsZero), .timerIsOne(timerIsOne),
    .irqPending(irqPending), .irqPin(irqPin), .slowTick(slowTick),
    .idleAck(idleAck), .pllLock(pllLock), .strobe(strobe),
    .clkEnable(clkEnable), .pllOff(pllOff), .pdActive(pdActive)
  );

  pdwake_regs #(.CNT_W(CNT_W)) uRegs (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .strobe(strobe),
    .startReq(startReq), .pllStopCfg(pllStopCfg),
    .alarmIsZero(alarmIsZero), .timerIsOne(timerIsOne)
  );
endmodule

// File: tb/tb_pdwake_ctrl.sv
module tb_pdwake_ctrl;
  localparam int CNT_W = 16;
  localparam int NVEC  = 5;
  localparam int NONE  = 255;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [CNT_W-1:0] regWrData = '0;
  logic [CNT_W-1:0] regRdData;
  logic irqPending = 1'b0, irqPin = 1'b0, slowTick = 1'b0;
  logic idleAck = 1'b1, pllLock = 1'b1;
  logic clkEnable, pllOff, pdActive;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pdwake_ctrl #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irqPending(irqPending),
    .irqPin(irqPin), .slowTick(slowTick), .idleAck(idleAck), .pllLock(pllLock),
    .clkEnable(clkEnable), .pllOff(pllOff), .pdActive(pdActive)
  );

  // alarm, pllStop, ticks before pin (NONE = alarm wake), cause, remaining timer
  typedef struct packed {
    logic [15:0] alarm;
    logic        pllStop;
    logic [7:0]  pinAfter;
    logic [2:0]  cause;
    logic [15:0] timerLeft;
  } vec_t;
  localparam vec_t VECS [NVEC] = '{
    '{16'd5,  1'b0, 8'd255, 3'b010, 16'd0},
    '{16'd3,  1'b1, 8'd255, 3'b010, 16'd0},
    '{16'd8,  1'b0, 8'd2,   3'b001, 16'd6},
    '{16'd1,  1'b0, 8'd255, 3'b010, 16'd0},
    '{16'd10, 1'b1, 8'd0,   3'b001, 16'd10}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [CNT_W-1:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [CNT_W-1:0] d);
    regAddr = a;
    #0.5;
    d = regRdData;
  endtask

  task automatic tick();
    @(negedge clk); slowTick = 1'b1;
    @(negedge clk); slowTick = 1'b0;
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [CNT_W-1:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 clkEnable", clkEnable, 1);
    check("R1 pllOff", pllOff, 0);
    check("R1 pdActive", pdActive, 0);
    rd(2'd3, r); check("R1 status", r, 0);
    rd(2'd2, r); check("R1 timer", r, 0);
    rstN = 1'b1;

    // R2 register read/write
    wr(2'd0, 16'h1234); rd(2'd0, r); check("R2 alarm", r, 16'h1234);
    wr(2'd2, 16'h00ab); rd(2'd2, r); check("R2 timer", r, 16'h00ab);

    // table-driven power-down cycles
    for (int i = 0; i < NVEC; i++) begin
      wr(2'd0, VECS[i].alarm);
      wr(2'd1, {14'd0, VECS[i].pllStop, 1'b1});
      check("R4 enter keeps clock", clkEnable, 1);
      check("R4 pdActive", pdActive, 1);
      @(negedge clk);
      check("R4 clock stopped", clkEnable, 0);
      check("R8 pllOff", pllOff, VECS[i].pllStop);
      if (VECS[i].pinAfter == NONE[7:0]) begin
        for (int t = 0; t < int'(VECS[i].alarm); t++) tick();
      end else begin
        for (int t = 0; t < int'(VECS[i].pinAfter); t++) tick();
        @(negedge clk); irqPin = 1'b1;
        @(negedge clk); irqPin = 1'b0;
      end
      check("R9 wake still gated", clkEnable, 0);
      check("R8 pllOff low in wake", pllOff, 0);
      @(negedge clk);
      check("R9 clock back", clkEnable, 1);
      rd(2'd3, r); check("R6 R7 cause", r, {13'd0, VECS[i].cause});
      rd(2'd2, r); check("R11 R5 timer left", r, VECS[i].timerLeft);
    end

    // R5 no early expiry: alarm 3, two ticks keep it down
    wr(2'd0, 16'd3); wr(2'd1, 16'd1);
    @(negedge clk);
    tick(); tick();
    @(negedge clk);
    check("R5 still down after 2 ticks", clkEnable, 0);
    tick();
    @(negedge clk);
    check("R5 wakes on third tick", clkEnable, 1);

    // R7 simultaneous causes
    wr(2'd0, 16'd2); wr(2'd1, 16'd1);
    @(negedge clk);
    tick();
    @(negedge clk); slowTick = 1'b1; irqPin = 1'b1;
    @(negedge clk); slowTick = 1'b0; irqPin = 1'b0;
    @(negedge clk);
    rd(2'd3, r); check("R7 both causes", r, 3'b011);

    // R9 wait for lock
    pllLock = 1'b0;
    wr(2'd0, 16'd4); wr(2'd1, 16'd3);
    @(negedge clk);
    @(negedge clk); irqPin = 1'b1;
    @(negedge clk); irqPin = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 gated without lock", clkEnable, 0);
    pllLock = 1'b1;
    @(negedge clk);
    check("R9 released after lock", clkEnable, 1);
    rd(2'd1, r); check("R2 ctrl readback", r, 16'd2);

    // R4 handshake hold
    idleAck = 1'b0;
    wr(2'd0, 16'd2); wr(2'd1, 16'd1);
    repeat (3) @(negedge clk);
    check("R4 held by idleAck", clkEnable, 1);
    idleAck = 1'b1;
    @(negedge clk);
    check("R4 gated after ack", clkEnable, 0);
    check("R8 pll kept", pllOff, 0);
    tick(); tick();
    @(negedge clk);

    // R3 refused start
    irqPending = 1'b1;
    wr(2'd0, 16'd5); wr(2'd1, 16'd1);
    check("R3 no pdActive", pdActive, 0);
    @(negedge clk);
    check("R3 clock kept", clkEnable, 1);
    rd(2'd3, r); check("R3 reject flag", r, 3'b100);
    irqPending = 1'b0;
    irqPin = 1'b1;
    wr(2'd1, 16'd1);
    check("R3 pin blocks", pdActive, 0);
    irqPin = 1'b0;

    // R10 zero alarm
    wr(2'd0, 16'd0); wr(2'd1, 16'd1);
    check("R10 no pdActive", pdActive, 0);
    check("R10 clock kept", clkEnable, 1);
    rd(2'd3, r); check("R10 status", r, 3'b010);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule